// File: doc/BRIEF.md
# Clock-Gated Serial Receive Datapath

This block is the receive datapath of a power-managed serial peripheral. Serial bits are collected into a parallel word by a shift register that is clocked only while receiving is worth the power. Two qualifiers decide that: one says the receive path is active, the other says the line is idle. The clock gate is a latch followed by an AND gate. Its enable is first captured in a flop on the free-running peripheral clock. The enable therefore only changes just after a rising edge, and the gated clock carries only whole high phases.

A bit counter on the gated clock marks the end of each word with a one-cycle pulse in the peripheral clock domain. A busy flag is raised by the first bit of a word and dropped by its last bit. The flag reaches a separate system clock domain through a chain of synchronizer flops. Baud timing, framing checks, transmit and any bus access belong to neighbouring blocks.

Top module: `rxg_gated_rx`

## Requirements
- R1: The gating condition is `rx_active & ~line_idle`, sampled on each rising `pclk` edge. A shift takes place on a rising `pclk` edge only when the condition was sampled true on the previous rising edge. Changes of the qualifiers between edges have no effect.
- R2: The gated clock rises only together with a rising `pclk` edge and stays high for a full `pclk` high phase. The latched enable never changes while `pclk` is high.
- R3: Each shift loads `sdi` into bit 7 of `rx_data` and moves every other bit one place toward bit 0. A word therefore arrives least significant bit first.
- R4: After every eighth shift since reset, `frame_done` is 1 for exactly the one `pclk` cycle that follows that shift. During that cycle `rx_data` holds the completed word.
- R5: Busy goes to 1 on the first shift of a word and to 0 on its eighth shift. `busy_sys` follows each change within three rising `sclk` edges.
- R6: While no shift takes place, `rx_data` and the bit position are held, and `frame_done` stays 0. Serial input presented during a gated-off cycle is never captured.
- R7: While `rst_n` is 0, `rx_data`, `frame_done` and `busy_sys` are 0, independent of either clock. A reset in the middle of a word restarts the bit count, so the next eight shifts form a complete word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Free-running peripheral clock |
| sclk | input | 1 | System clock that receives the busy flag |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sdi | input | 1 | Serial data, sampled on gated edges |
| rx_active | input | 1 | Receive path active qualifier |
| line_idle | input | 1 | Line idle qualifier, blocks gating when 1 |
| rx_data | output | 8 | Parallel shift register contents |
| frame_done | output | 1 | One-cycle pulse after the eighth bit of a word |
| busy_sys | output | 1 | Busy flag synchronized to `sclk` |

## Verification
Suppose the bit counter or the shift contents take a wrong value. This shows at the ports one `pclk` cycle after the faulty shift: `frame_done` comes early, late or twice, and the word read at the pulse is wrong. A fault in the gate enable, or its capture, shows in the same cycle as an extra or missing shift. It is detected by presenting serial bits during gated-off cycles and by moving the qualifiers between edges. A fault in the busy flag or its synchronizer shows on `busy_sys` within three `sclk` edges of the first or last bit.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  // Default word width and synchronizer depth shared by the block.
  localparam int unsigned RXG_WORD_W  = 8;
  localparam int unsigned RXG_SYNC_N  = 2;

  // Bit position counter width for a given word width.
  function automatic int unsigned rxg_cnt_w(input int unsigned word_w);
    return (word_w > 1) ? $clog2(word_w) : 1;
  endfunction
endpackage

// File: rtl/rxg_enable_reg.sv
module rxg_enable_reg (
  input  logic pclk,
  input  logic rst_n,
  input  logic rx_active,
  input  logic line_idle,
  output logic en_q
);
  logic en_d;

  // Gating condition; only the registered copy reaches the clock gate.
  always_comb begin
    en_d = rx_active & ~line_idle;
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/rxg_clock_gate.sv
module rxg_clock_gate (
  input  logic pclk,
  input  logic rst_n,
  input  logic en_i,
  output logic gclk_o
);
  logic en_lat;

  // Transparent while the clock is low, holds through the high phase.
  always_latch begin
    if (!rst_n)     en_lat = 1'b0;
    else if (!pclk) en_lat = en_i;
  end

  assign gclk_o = pclk & en_lat;

  // The held enable may only move while the clock is low.
  always @(en_lat) begin
    if (rst_n === 1'b1) begin
      AST_GATE_HELD: assert (pclk !== 1'b1) else $error("gate enable moved in high phase"); // R2
    end
  end
endmodule

// File: rtl/rxg_shift_core.sv
module rxg_shift_core #(
  parameter int unsigned WORD_W = rxg_pkg::RXG_WORD_W
) (
  input  logic              gclk,
  input  logic              rst_n,
  input  logic              sdi,
  output logic [WORD_W-1:0] data_o,
  output logic              busy_o,
  output logic              tog_o
);
  localparam int unsigned CNT_W = rxg_pkg::rxg_cnt_w(WORD_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d;
  logic              tog_q, tog_d;
  logic              last;

  // Next state: every gated edge is one received bit.
  always_comb begin
    last    = (cnt_q == LAST_POS);
    shift_d = {sdi, shift_q[WORD_W-1:1]};
    cnt_d   = last ? '0 : cnt_q + 1'b1;
    busy_d  = ~last;
    tog_d   = tog_q ^ last;
  end

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
      tog_q   <= tog_d;
    end
  end

  assign data_o = shift_q;
  assign busy_o = busy_q;
  assign tog_o  = tog_q;

  // Busy is only low between words, i.e. with the count at its start.
  AST_IDLE_AT_START: assert property (@(posedge gclk) disable iff (!rst_n)
    !busy_q |-> (cnt_q == '0)) else $error("busy low mid-word"); // R5
endmodule

// File: rtl/rxg_done_pulse.sv
module rxg_done_pulse (
  input  logic pclk,
  input  logic rst_n,
  input  logic tog_i,
  output logic done_o
);
  logic seen_q;

  // Follows the word toggle one free-running cycle later.
  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= tog_i;
  end

  assign done_o = tog_i ^ seen_q;

  AST_DONE_SINGLE: assert property (@(posedge pclk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("word pulse longer than one cycle"); // R4
endmodule

// File: rtl/rxg_sync.sv
module rxg_sync #(
  parameter int unsigned STAGES = rxg_pkg::RXG_SYNC_N
) (
  input  logic sclk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge sclk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge sclk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rxg_gated_rx.sv
module rxg_gated_rx #(
  parameter int unsigned WORD_W = rxg_pkg::RXG_WORD_W,
  parameter int unsigned SYNC_N = rxg_pkg::RXG_SYNC_N
) (
  input  logic              pclk,
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              rx_active,
  input  logic              line_idle,
  output logic [WORD_W-1:0] rx_data,
  output logic              frame_done,
  output logic              busy_sys
);
  logic en_q;
  logic gclk;
  logic busy_src;
  logic word_tog;

  rxg_enable_reg u_en (
    .pclk      (pclk),
    .rst_n     (rst_n),
    .rx_active (rx_active),
    .line_idle (line_idle),
    .en_q      (en_q)
  );

  rxg_clock_gate u_cg (
    .pclk   (pclk),
    .rst_n  (rst_n),
    .en_i   (en_q),
    .gclk_o (gclk)
  );

  rxg_shift_core #(.WORD_W(WORD_W)) u_core (
    .gclk   (gclk),
    .rst_n  (rst_n),
    .sdi    (sdi),
    .data_o (rx_data),
    .busy_o (busy_src),
    .tog_o  (word_tog)
  );

  rxg_done_pulse u_done (
    .pclk   (pclk),
    .rst_n  (rst_n),
    .tog_i  (word_tog),
    .done_o (frame_done)
  );

  rxg_sync #(.STAGES(SYNC_N)) u_sync (
    .sclk  (sclk),
    .rst_n (rst_n),
    .d_i   (busy_src),
    .q_o   (busy_sys)
  );

  // No gated edge without a registered enable, so the word holds.
  AST_HOLD_OFF: assert property (@(posedge pclk) disable iff (!rst_n)
    !$past(en_q) |-> $stable(rx_data)) else $error("shift while gated off"); // R6

  // A word can only end on a cycle that had a gated edge.
  AST_DONE_AFTER_SHIFT: assert property (@(posedge pclk) disable iff (!rst_n)
    frame_done |-> $past(en_q)) else $error("word end without a shift"); // R4

  // The source busy flag is down once a word has ended.
  AST_BUSY_CLEAR: assert property (@(posedge pclk) disable iff (!rst_n)
    frame_done |-> !busy_src) else $error("busy still set at word end"); // R5
endmodule

// File: tb/tb_rxg_gated_rx.sv
module tb_rxg_gated_rx;
  localparam int PCLK_T = 10;
  localparam int SCLK_T = 14;
  localparam int NV = 26;
  // Each row: {rx_active, line_idle, sdi}
  localparam logic [2:0] VEC [NV] = '{
    3'b100, 3'b101, 3'b110, 3'b001, 3'b101, 3'b101, 3'b010, 3'b011,
    3'b101, 3'b100, 3'b101, 3'b110, 3'b101, 3'b001, 3'b000, 3'b100,
    3'b100, 3'b100, 3'b101, 3'b101, 3'b101, 3'b101, 3'b100, 3'b000,
    3'b001, 3'b000 };
  localparam logic [7:0] WORDS [2] = '{8'hA5, 8'h3C};

  logic pclk = 1'b0, sclk = 1'b0, rst_n = 1'b0;
  logic sdi = 1'b0, rx_active = 1'b0, line_idle = 1'b0;
  logic [7:0] rx_data;
  logic frame_done, busy_sys;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #(PCLK_T/2) pclk = ~pclk;
  always #(SCLK_T/2) sclk = ~sclk;

  rxg_gated_rx dut (
    .pclk(pclk), .sclk(sclk), .rst_n(rst_n), .sdi(sdi),
    .rx_active(rx_active), .line_idle(line_idle),
    .rx_data(rx_data), .frame_done(frame_done), .busy_sys(busy_sys));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Send one word LSB first with the enable held on for exactly eight shifts.
  task automatic send_word(input logic [7:0] w);
    @(negedge pclk); rx_active = 1'b1; line_idle = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge pclk); sdi = w[i];
      if (i == 7) rx_active = 1'b0;
    end
    @(negedge pclk);
    chk("R4", frame_done, 1'b1);
    chk("R3", rx_data, w);
    @(negedge pclk);
    chk("R4", frame_done, 1'b0);
  endtask

  initial begin
    #(PCLK_T * 200000);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic       m_en;
    logic [7:0] m_data;
    int         m_cnt, m_words;
    logic       m_done;
    logic [7:0] hold;
    int         n;

    // R7: reset state
    #3;
    chk("R7", rx_data, 8'h00);
    chk("R7", frame_done, 1'b0);
    chk("R7", busy_sys, 1'b0);
    @(negedge pclk); @(negedge pclk); rst_n = 1'b1;

    // Table walk against a reference model of R1, R3, R4, R6
    m_en = 0; m_data = '0; m_cnt = 0; m_done = 0; m_words = 0;
    for (int i = 0; i < NV; i++) begin
      @(negedge pclk);
      chk("R3/R6", rx_data, m_data);
      chk("R4", frame_done, m_done);
      if (m_done) begin
        chk("R3", rx_data, WORDS[m_words]);
        m_words++;
      end
      {rx_active, line_idle, sdi} = VEC[i];
      @(posedge pclk);
      m_done = 1'b0;
      if (m_en) begin
        m_data = {sdi, m_data[7:1]};
        m_cnt++;
        if (m_cnt == 8) begin m_cnt = 0; m_done = 1'b1; end
      end
      m_en = rx_active & ~line_idle;
    end
    @(negedge pclk);
    chk("R4", m_words, 2);

    // R1/R2: qualifiers moved between edges and idle-blocked enable never shift
    hold = rx_data;
    sdi = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge pclk); #2 rx_active = 1'b1; #2 rx_active = 1'b0;
    end
    @(negedge pclk); rx_active = 1'b1; line_idle = 1'b1;
    repeat (4) @(negedge pclk);
    chk("R1", rx_data, hold);
    chk("R2", frame_done, 1'b0);
    rx_active = 1'b0; line_idle = 1'b0;

    // R5: busy_sys latency on rise and fall
    @(negedge pclk); rx_active = 1'b1; sdi = 1'b1;
    @(posedge pclk); @(posedge pclk); #1;
    n = 0;
    for (int k = 1; k <= 4; k++) begin
      @(posedge sclk); #1;
      if (busy_sys) begin n = k; break; end
    end
    chk("R5", (n >= 1 && n <= 3), 1'b1);
    n = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge pclk);
      if (k == 4) rx_active = 1'b0;
      if (frame_done) begin n = 1; break; end
    end
    chk("R4", n, 1);
    chk("R3", rx_data, 8'hFF);
    n = 0;
    for (int k = 1; k <= 4; k++) begin
      @(posedge sclk); #1;
      if (!busy_sys) begin n = k; break; end
    end
    chk("R5", (n >= 1 && n <= 3), 1'b1);

    // R7: reset in the middle of a word, then a full word
    @(negedge pclk); rx_active = 1'b1; sdi = 1'b1;
    repeat (4) @(negedge pclk);
    rst_n = 1'b0; rx_active = 1'b0; #2;
    chk("R7", rx_data, 8'h00);
    chk("R7", frame_done, 1'b0);
    @(negedge pclk); rst_n = 1'b1;
    #1 chk("R7", busy_sys, 1'b0);
    send_word(8'h81);
    send_word(8'h5A);

    finish_run();
  end
endmodule